// File: doc/BRIEF.md
# System Clock Source Selector with Oscillator-Loss Fallback

This block picks the system clock from one of three sources: an always-running internal oscillator, an external main oscillator and a multiplied PLL output. Two interlocks guard the choice. A request for the PLL output takes effect only while the PLL reports lock. When the main oscillator stops toggling, the block moves the system clock onto the internal oscillator by itself and raises a failure flag. Every change of source goes through a glitch-free hand-over.

The system clock feeds two cascaded power-of-two prescalers. The first produces the AHB clock and the second produces the APB clock from the AHB clock. A timer clock taps the APB chain at either the APB rate or twice that rate. A second PLL output reaches the USB clock pin only through an enable. A clock-output pin picks one of four internal clocks and can halve its frequency.

The main-oscillator watchdog runs on the internal oscillator. It counts internal-clock cycles between observed main-oscillator transitions. When the count reaches a programmable limit, it sets a sticky failure flag. Only reset clears this flag.

Top module: `clk_source_switch`

## Requirements
- R1: After reset is released, the system clock runs at the internal-oscillator frequency. The failure flag and the interrupt are low, and the USB clock stays low.
- R2: With the PLL enabled and the PLL requested, the system clock follows the main oscillator while lock is low. It follows the PLL output once lock is high.
- R3: With the PLL disabled, the system clock follows the internal oscillator whatever the PLL request and lock inputs are.
- R4: The failure flag rises when the main oscillator stops toggling for longer than the programmed limit, counted in internal-oscillator cycles. The flag stays clear while the main oscillator runs. Once set, it forces the system clock to the internal oscillator, even if the main oscillator restarts or the PLL is requested. Only reset clears it.
- R5: The failure interrupt equals the failure flag while the interrupt enable is high, and is low otherwise.
- R6: The AHB divide code selects division of the system clock as follows: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8.
- R7: The APB divide code selects division of the AHB clock as follows: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 and 4 gives /16. Codes 5 to 7 also give /16.
- R8: When the double-rate bit is set and the effective APB code is nonzero, the timer clock runs at twice the APB frequency. In every other case it equals the APB clock.
- R9: The USB clock stays low while its enable is low. It carries the second PLL output while the enable is high.
- R10: The clock-output select code chooses the source as follows: 0 is the second PLL output, 1 is the AHB clock, 2 is the APB clock and 3 is the main oscillator. The halve bit divides the selected clock by two.
- R11: At most one source is enabled into the system clock at any time. No high or low phase of the system clock is shorter than the shortest half period of any source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal free-running oscillator; also the watchdog reference |
| main_clk | input | 1 | Main oscillator |
| pll_clk | input | 1 | Multiplied PLL output for the system clock |
| pll2_clk | input | 1 | Second PLL output for USB and clock-out |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | PLL enable |
| pll_sel | input | 1 | Request for the PLL as system clock source |
| pll_lock | input | 1 | PLL lock indication |
| ahb_div | input | 2 | AHB divide code |
| apb_div | input | 3 | APB divide code |
| tim_x2 | input | 1 | Timer clock at twice the APB rate |
| usb_en | input | 1 | USB clock enable |
| mco_sel | input | 2 | Clock-output source code |
| mco_half | input | 1 | Halve the clock-output frequency |
| det_limit | input | 8 | Watchdog limit in reference cycles |
| fail_irq_en | input | 1 | Failure interrupt enable |
| sys_clk | output | 1 | System clock |
| ahb_clk | output | 1 | AHB clock |
| apb_clk | output | 1 | APB clock |
| tim_clk | output | 1 | Timer clock |
| usb_clk | output | 1 | Gated USB clock |
| mco_clk | output | 1 | Clock-output pin |
| clk_fail | output | 1 | Sticky main-oscillator failure flag |
| fail_irq | output | 1 | Failure interrupt |

## Verification
The properties assume the following about the inputs:
- Lock does not pulse for less than three reference cycles.
- The USB enable changes at most once between two edges of the second PLL output.
- The watchdog limit exceeds the number of reference cycles that a running main oscillator can go without a visible transition.

The stimulus keeps to these assumptions. It uses a main-oscillator period of 16 ns against a 10 ns reference with a limit of 8. It changes lock and the enables only at slow, widely spaced points. It holds every divider and select code static while a period is measured. A separate monitor records the shortest system-clock phase over the whole run, including every hand-over between sources.

// File: rtl/clk_switch_pkg.sv
`timescale 1ns/1ps
package clk_switch_pkg;

   // Index of each source in the enable vector of the switch
   typedef enum logic [1:0] {
      SRC_FREE = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_PLL  = 2'd2
   } clk_src_e;

   localparam int NUM_SRC = 3;

   function automatic logic [NUM_SRC-1:0] src_bit(clk_src_e s);
      return NUM_SRC'(1) << s;
   endfunction

endpackage

// File: rtl/glitchless_clk_mux.sv
`timescale 1ns/1ps
module glitchless_clk_mux #(
   parameter int N       = 3,
   parameter int RST_SRC = 0
) (
   input  logic [N-1:0] clk_in,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] kill,
   output logic [N-1:0] en,
   output logic         clk_out
);

   if (N < 2) begin : g_bad_n
      $error("glitchless_clk_mux: N must be at least 2");
   end
   if (RST_SRC >= N) begin : g_bad_rst
      $error("glitchless_clk_mux: RST_SRC out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_leg
      localparam logic RV = (i == RST_SRC);
      logic s1, s2, e, d, clr;

      // a leg may start only once every other leg has let go
      assign d   = req[i] & ~(|(en & ~(N'(1) << i)));
      assign clr = ~rst_n | kill[i];

      always_ff @(posedge clk_in[i] or posedge clr) begin
         if (clr) begin
            s1 <= RV;
            s2 <= RV;
         end else begin
            s1 <= d;
            s2 <= s1;
         end
      end

      // enable changes only while this clock is low
      always_ff @(negedge clk_in[i] or posedge clr) begin
         if (clr) e <= RV;
         else     e <= s2;
      end

      assign en[i] = e;
   end

   assign clk_out = |(clk_in & en);

   p_one_source_r11: assert property (@(posedge clk_in[RST_SRC]) disable iff (!rst_n)
      $onehot0(en));

endmodule

// File: rtl/osc_loss_detector.sv
`timescale 1ns/1ps
module osc_loss_detector #(
   parameter int CNT_W = 8
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             mon_clk,
   input  logic [CNT_W-1:0] limit,
   output logic             fail
);

   if (CNT_W < 2) begin : g_bad_w
      $error("osc_loss_detector: CNT_W must be at least 2");
   end

   logic [2:0]       sync_q;
   logic [CNT_W-1:0] cnt_q;
   logic             seen;

   assign seen = sync_q[2] ^ sync_q[1];

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         cnt_q  <= '0;
         fail   <= 1'b0;
      end else begin
         sync_q <= {sync_q[1:0], mon_clk};
         if (seen)
            cnt_q <= '0;
         else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
         if (!seen && cnt_q >= limit)
            fail <= 1'b1;
      end
   end

   p_fail_sticky_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      fail |=> fail);

endmodule

// File: rtl/pow2_clk_divider.sv
`timescale 1ns/1ps
module pow2_clk_divider #(
   parameter int STAGES = 4,
   localparam int SEL_W = $clog2(STAGES + 1)
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   output logic [STAGES:0]   taps,
   output logic              clk_out
);

   if (STAGES < 1) begin : g_bad_st
      $error("pow2_clk_divider: STAGES must be at least 1");
   end

   logic [STAGES-1:0] cnt_q;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   // tap k carries clk_in divided by 2**k
   assign taps    = {cnt_q, clk_in};
   assign clk_out = taps[sel];

endmodule

// File: rtl/clk_source_switch.sv
`timescale 1ns/1ps
module clk_source_switch
   import clk_switch_pkg::*;
#(
   parameter int DET_W      = 8,
   parameter int AHB_STAGES = 3,
   parameter int APB_STAGES = 4
) (
   input  logic                                ref_clk,
   input  logic                                main_clk,
   input  logic                                pll_clk,
   input  logic                                pll2_clk,
   input  logic                                rst_n,
   input  logic                                pll_en,
   input  logic                                pll_sel,
   input  logic                                pll_lock,
   input  logic [$clog2(AHB_STAGES+1)-1:0]     ahb_div,
   input  logic [$clog2(APB_STAGES+1)-1:0]     apb_div,
   input  logic                                tim_x2,
   input  logic                                usb_en,
   input  logic [1:0]                          mco_sel,
   input  logic                                mco_half,
   input  logic [DET_W-1:0]                    det_limit,
   input  logic                                fail_irq_en,
   output logic                                sys_clk,
   output logic                                ahb_clk,
   output logic                                apb_clk,
   output logic                                tim_clk,
   output logic                                usb_clk,
   output logic                                mco_clk,
   output logic                                clk_fail,
   output logic                                fail_irq
);

   localparam int APB_SEL_W = $clog2(APB_STAGES + 1);

   logic [NUM_SRC-1:0] req, kill, src_en, clks;

   // ---------------- source choice with interlocks ----------------
   always_comb begin
      if (clk_fail || !pll_en)    req = src_bit(SRC_FREE);
      else if (pll_sel && pll_lock) req = src_bit(SRC_PLL);
      else                          req = src_bit(SRC_MAIN);
   end

   // a dead oscillator cannot clock its own leg off, so clear it directly
   assign kill = clk_fail ? src_bit(SRC_MAIN) : '0;
   assign clks = {pll_clk, main_clk, ref_clk};

   glitchless_clk_mux #(.N(NUM_SRC), .RST_SRC(int'(SRC_FREE))) u_mux (
      .clk_in (clks),
      .rst_n  (rst_n),
      .req    (req),
      .kill   (kill),
      .en     (src_en),
      .clk_out(sys_clk)
   );

   osc_loss_detector #(.CNT_W(DET_W)) u_det (
      .ref_clk(ref_clk),
      .rst_n  (rst_n),
      .mon_clk(main_clk),
      .limit  (det_limit),
      .fail   (clk_fail)
   );

   assign fail_irq = clk_fail & fail_irq_en;

   // ---------------- bus prescalers ----------------
   logic [AHB_STAGES:0]    ahb_taps;
   logic [APB_STAGES:0]    apb_taps;
   logic [APB_SEL_W-1:0]   apb_c, tim_idx;

   always_comb begin
      if (apb_div > APB_SEL_W'(APB_STAGES)) apb_c = APB_SEL_W'(APB_STAGES);
      else                                  apb_c = apb_div;
   end

   pow2_clk_divider #(.STAGES(AHB_STAGES)) u_ahb_div (
      .clk_in (sys_clk),
      .rst_n  (rst_n),
      .sel    (ahb_div),
      .taps   (ahb_taps),
      .clk_out(ahb_clk)
   );

   pow2_clk_divider #(.STAGES(APB_STAGES)) u_apb_div (
      .clk_in (ahb_clk),
      .rst_n  (rst_n),
      .sel    (apb_c),
      .taps   (apb_taps),
      .clk_out(apb_clk)
   );

   assign tim_idx = apb_c - APB_SEL_W'(1);
   assign tim_clk = (tim_x2 && apb_c != '0) ? apb_taps[tim_idx] : apb_clk;

   // ---------------- USB gate ----------------
   logic usb_on;
   always_ff @(negedge pll2_clk or negedge rst_n) begin
      if (!rst_n) usb_on <= 1'b0;
      else        usb_on <= usb_en;
   end
   assign usb_clk = pll2_clk & usb_on;

   // ---------------- clock-output pin ----------------
   logic mco_src, mco_t;
   always_comb begin
      case (mco_sel)
         2'd0:    mco_src = pll2_clk;
         2'd1:    mco_src = ahb_clk;
         2'd2:    mco_src = apb_clk;
         default: mco_src = main_clk;
      endcase
   end

   always_ff @(posedge mco_src or negedge rst_n) begin
      if (!rst_n) mco_t <= 1'b0;
      else        mco_t <= ~mco_t;
   end
   assign mco_clk = mco_half ? mco_t : mco_src;

   // ---------------- properties ----------------
   p_fail_blocks_main_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      clk_fail |=> !src_en[SRC_MAIN]);

   p_pll_needs_lock_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!pll_lock && $past(!pll_lock) && $past(!pll_lock, 2)) |-> !src_en[SRC_PLL]);

   p_usb_gated_r9: assert property (@(posedge pll2_clk) disable iff (!rst_n)
      (!usb_en && $past(!usb_en)) |-> !usb_on);

endmodule

// File: tb/clk_source_switch_tb_top.sv
`timescale 1ns/1ps
module clk_source_switch_tb_top;

   localparam real CLK_PERIOD = 10.0;
   localparam real MAIN_HALF  = 8.0;
   localparam real PLL_HALF   = 2.0;
   localparam real PLL2_HALF  = 3.0;

   logic ref_clk = 0, main_clk = 0, pll_clk = 0, pll2_clk = 0, rst_n = 0;
   logic pll_en = 0, pll_sel = 0, pll_lock = 0, tim_x2 = 0, usb_en = 0;
   logic mco_half = 0, fail_irq_en = 0, main_run = 1;
   logic [1:0] ahb_div = 0, mco_sel = 0;
   logic [2:0] apb_div = 0;
   logic [7:0] det_limit = 8'd8;
   logic sys_clk, ahb_clk, apb_clk, tim_clk, usb_clk, mco_clk, clk_fail, fail_irq;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
   always #(MAIN_HALF) if (main_run) main_clk = ~main_clk;
   always #(PLL_HALF)  pll_clk  = ~pll_clk;
   always #(PLL2_HALF) pll2_clk = ~pll2_clk;

   clk_source_switch dut_i (
      .ref_clk(ref_clk), .main_clk(main_clk), .pll_clk(pll_clk), .pll2_clk(pll2_clk),
      .rst_n(rst_n), .pll_en(pll_en), .pll_sel(pll_sel), .pll_lock(pll_lock),
      .ahb_div(ahb_div), .apb_div(apb_div), .tim_x2(tim_x2), .usb_en(usb_en),
      .mco_sel(mco_sel), .mco_half(mco_half), .det_limit(det_limit),
      .fail_irq_en(fail_irq_en), .sys_clk(sys_clk), .ahb_clk(ahb_clk),
      .apb_clk(apb_clk), .tim_clk(tim_clk), .usb_clk(usb_clk), .mco_clk(mco_clk),
      .clk_fail(clk_fail), .fail_irq(fail_irq)
   );

   // period monitors: last full period between rising edges
   real t_sys = 0, p_sys = 0, t_ahb = 0, p_ahb = 0, t_apb = 0, p_apb = 0;
   real t_tim = 0, p_tim = 0, t_usb = 0, p_usb = 0, t_mco = 0, p_mco = 0;
   int  usb_edges = 0;
   always @(posedge sys_clk) begin p_sys = $realtime - t_sys; t_sys = $realtime; end
   always @(posedge ahb_clk) begin p_ahb = $realtime - t_ahb; t_ahb = $realtime; end
   always @(posedge apb_clk) begin p_apb = $realtime - t_apb; t_apb = $realtime; end
   always @(posedge tim_clk) begin p_tim = $realtime - t_tim; t_tim = $realtime; end
   always @(posedge usb_clk) begin p_usb = $realtime - t_usb; t_usb = $realtime; usb_edges++; end
   always @(posedge mco_clk) begin p_mco = $realtime - t_mco; t_mco = $realtime; end

   // shortest system-clock phase, outside reset
   real t_any = 0, min_w = 1.0e9;
   always @(sys_clk) begin
      if (rst_n && ($realtime - t_any) < min_w) min_w = $realtime - t_any;
      t_any = $realtime;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0.2f expected %0.2f", req, what, act, exp);
      end
   endtask

   task automatic chk_per(input string req, input string what, input real act, input real exp);
      chk((act - exp < 0.5) && (exp - act < 0.5), req, what, act, exp);
   endtask

   task automatic settle(input int ns);
      #(ns);
      @(negedge ref_clk);
   endtask

   // stimulus table: pll_en, pll_sel, lock, ahb code, apb code, x2, expected sys period
   typedef struct packed {
      logic       pe;
      logic       ps;
      logic       lk;
      logic [1:0] ah;
      logic [2:0] ap;
      logic       td;
      logic [7:0] sysp;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 8'd10},  // R3 free
      '{1'b0, 1'b1, 1'b1, 2'd1, 3'd2, 1'b0, 8'd10},  // R3 request ignored while disabled
      '{1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 8'd16},  // R2 main
      '{1'b1, 1'b1, 1'b0, 2'd2, 3'd1, 1'b1, 8'd16},  // R2 no lock -> main
      '{1'b1, 1'b1, 1'b1, 2'd3, 3'd4, 1'b1, 8'd4},   // R2 locked -> PLL
      '{1'b1, 1'b1, 1'b1, 2'd1, 3'd7, 1'b0, 8'd4},   // R7 clamp
      '{1'b1, 1'b0, 1'b1, 2'd0, 3'd3, 1'b1, 8'd16},
      '{1'b1, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 8'd4}    // R8 x2 with code 0
   };

   always @(posedge ref_clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      real e_sys, e_ahb, e_apb, e_tim;
      int  e0;
      repeat (3) @(negedge ref_clk);
      rst_n = 1;
      settle(200);
      // R1 reset state
      chk_per("R1", "sys period after reset", p_sys, 10.0);
      chk(clk_fail == 0, "R1", "fail flag", clk_fail, 0);
      chk(fail_irq == 0, "R1", "irq", fail_irq, 0);
      chk(usb_edges == 0, "R1", "usb edges", usb_edges, 0);

      for (int i = 0; i < NV; i++) begin
         pll_en = VECS[i].pe; pll_sel = VECS[i].ps; pll_lock = VECS[i].lk;
         ahb_div = VECS[i].ah; apb_div = VECS[i].ap; tim_x2 = VECS[i].td;
         settle(2500);
         e_sys = real'(VECS[i].sysp);
         e_ahb = e_sys * (2.0 ** VECS[i].ah);
         e0    = (VECS[i].ap > 4) ? 4 : int'(VECS[i].ap);
         e_apb = e_ahb * (2.0 ** e0);
         e_tim = (VECS[i].td && e0 != 0) ? e_apb / 2.0 : e_apb;
         chk_per(VECS[i].pe ? "R2" : "R3", "sys period", p_sys, e_sys);
         chk_per("R6", "ahb period", p_ahb, e_ahb);
         chk_per("R7", "apb period", p_apb, e_apb);
         chk_per("R8", "tim period", p_tim, e_tim);
      end

      // R10 clock-out selection, with PLL at 4 ns, AHB /2, APB /2
      pll_en = 1; pll_sel = 1; pll_lock = 1; ahb_div = 1; apb_div = 1; tim_x2 = 0;
      mco_sel = 0; mco_half = 0; settle(400);
      chk_per("R10", "mco pll2", p_mco, 6.0);
      mco_sel = 1; settle(400);
      chk_per("R10", "mco ahb", p_mco, 8.0);
      mco_sel = 2; settle(400);
      chk_per("R10", "mco apb", p_mco, 16.0);
      mco_sel = 3; settle(400);
      chk_per("R10", "mco main", p_mco, 16.0);
      mco_half = 1; settle(400);
      chk_per("R10", "mco main halved", p_mco, 32.0);
      mco_sel = 0; settle(400);
      chk_per("R10", "mco pll2 halved", p_mco, 12.0);
      mco_half = 0;

      // R9 USB gate
      e0 = usb_edges; settle(300);
      chk(usb_edges == e0, "R9", "usb edges while disabled", usb_edges - e0, 0);
      usb_en = 1; settle(300);
      chk_per("R9", "usb period", p_usb, 6.0);

      // R4 / R5 oscillator loss while running from the main oscillator
      pll_sel = 0; fail_irq_en = 0; settle(600);
      chk(clk_fail == 0, "R4", "no fail while main runs", clk_fail, 0);
      chk_per("R4", "sys on main", p_sys, 16.0);
      main_run = 0; settle(600);
      chk(clk_fail == 1, "R4", "fail after loss", clk_fail, 1);
      chk(fail_irq == 0, "R5", "irq masked", fail_irq, 0);
      chk_per("R4", "sys fallback", p_sys, 10.0);
      fail_irq_en = 1; settle(50);
      chk(fail_irq == 1, "R5", "irq enabled", fail_irq, 1);
      main_run = 1; settle(600);
      chk(clk_fail == 1, "R4", "fail sticky", clk_fail, 1);
      chk_per("R4", "main stays blocked", p_sys, 10.0);
      pll_sel = 1; settle(600);
      chk_per("R4", "pll blocked on fail", p_sys, 10.0);

      // reset clears the flag and returns to the internal oscillator
      pll_en = 0; pll_sel = 0; pll_lock = 0; ahb_div = 0; apb_div = 0;
      usb_en = 0; fail_irq_en = 0;
      rst_n = 0; repeat (3) @(negedge ref_clk);
      rst_n = 1; settle(300);
      chk(clk_fail == 0, "R4", "fail cleared by reset", clk_fail, 0);
      chk_per("R1", "sys after second reset", p_sys, 10.0);

      // R11 no short phase during any hand-over
      chk(min_w > PLL_HALF - 0.01, "R11", "shortest sys phase", min_w, PLL_HALF);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule